// File: doc/BRIEF.md
# PWM Time Base Counter

This block is the timing core of a motor-control PWM unit. It holds a 15-bit count that steps on enabled clock ticks, after a selectable input divider. The count follows one of four patterns: it can wrap to zero at the period value, stop after a single period, or move up to the period value and back down to zero. Other logic compares the count against duty values and uses the direction flag to shape edge-aligned or centre-aligned waveforms. The event pulse marks period boundaries and can serve as an interrupt request or a trigger for duty updates.

Software reaches the block through three write strobes. The control strobe sets the enable, mode, input divider and event divider. The count strobe loads the count directly. The period strobe writes a staging copy of the period. The staging copy moves into the active period only at a safe point in the waveform, or at every cycle while the block is stopped, so a period change never cuts a cycle short. A status output flags a period of one, because that value would make the event fire on nearly every step.

Top module: `pwm_tbase`

## Requirements
- R1: After reset the count is 0, the block is stopped (run_o low), the direction flag is low, no event is pending, the active period is 0 and per_bad_o is low.
- R2: The input divider field selects 1, 4, 16 or 64 for codes 0, 1, 2 and 3. While running, the count takes one step per that many high cycles of tick_i.
- R3: A control write or a count write restarts both the input divider and the event divider from zero. A control write leaves the count value as it was. A count write loads cnt_wdata_i into the count. No step is taken in a cycle that carries either write.
- R4: In mode 00 (free-running) the count rises by one per step. The step taken when the count is at or above the active period returns it to 0, so one period lasts period+1 steps.
- R5: In mode 01 (single-shot) the count behaves as in mode 00 until its first return to 0. On that step the run bit clears, the event fires whatever the event divider setting is, and the count then stays at 0.
- R6: In mode 10 (up/down) the count rises to the active period. It then sets the direction flag and falls to 0, and the step taken at 0 clears the flag and moves the count to 1. One full cycle lasts twice the period in steps.
- R7: The event divider field N (0 to 15) makes the event fire once every N+1 period ends. In mode 00 a period end is a return to 0, and in mode 10 it is a reversal at 0. event_o is high for exactly one cycle, in the same cycle that the stepped count first appears.
- R8: In mode 11 (up/down with double update) the count moves as in mode 10. The event fires at both the reversal at the top and the reversal at 0, and the event divider field has no effect.
- R9: A period write only fills the staging copy. While running, the staging copy moves into the active period on the return to 0 in modes 00 and 01, and on the reversal at 0 in modes 10 and 11.
- R10: While the block is stopped, the active period takes the staging value on every clock.
- R11: per_bad_o is high exactly when the active period equals 1.
- R12: With tick_i low and no count write, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable for counting |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Run bit value for a control write |
| ctl_mode_i | input | 2 | Mode for a control write: 00 free, 01 single-shot, 10 up/down, 11 double update |
| ctl_pre_i | input | 2 | Input divider code: 0 gives /1, 1 gives /4, 2 gives /16, 3 gives /64 |
| ctl_post_i | input | 4 | Event divider: N gives one event per N+1 period ends |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 15 | Value for a count write |
| per_wr_i | input | 1 | Period staging write strobe |
| per_wdata_i | input | 15 | Value for a period write |
| count_o | output | 15 | Current count |
| dir_down_o | output | 1 | High while counting down |
| event_o | output | 1 | One-cycle event pulse |
| run_o | output | 1 | Run bit |
| per_bad_o | output | 1 | Active period equals 1 |

## Verification
Any wrong internal state shows up at the ports within a few cycles. A divider that lost its position moves the next count step, which count_o shows on the following cycle. A bad direction or active period changes the turning point on the next period, so the event spacing drifts at once. An event divider that is out of step shifts event_o by whole periods. The bench runs a behavioural model that tracks every output on every clock, so it catches the first wrong step. Directed checks then measure event spacing in each mode, the retained count after a control write and the moment at which the period copy takes effect.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_ONCE  = 2'b01,
        MODE_UPDN  = 2'b10,
        MODE_UPDN2 = 2'b11
    } tb_mode_e;

    function automatic logic mode_is_updn(tb_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc #(
    parameter int SEL_W    = 2,
    parameter int STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             stroke_o
);
    localparam int CW = STEP_LOG * ((1 << SEL_W) - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;
    logic [CW:0]   lim_w;
    logic [CW:0]   one_w;

    always_comb begin
        one_w = {{CW{1'b0}}, 1'b1};
        lim_w = (one_w << (STEP_LOG * sel_i)) - one_w;
        lim   = lim_w[CW-1:0];
    end

    assign stroke_o = adv_i && (cnt_q == lim);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            if (cnt_q == lim) cnt_d = '0;
            else              cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    presc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    // R3
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_tbase_post.sv
module pwm_tbase_post #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic [POST_W-1:0] ratio_i,
    output logic              fire_o
);
    logic [POST_W-1:0] cnt_d, cnt_q;

    assign fire_o = hit_i && (cnt_q == ratio_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (hit_i) begin
            if (cnt_q == ratio_i) cnt_d = '0;
            else                  cnt_d = cnt_q + {{(POST_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    post_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio_i);

endmodule

// File: rtl/pwm_tbase_period.sv
module pwm_tbase_period #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             load_i,
    input  logic             idle_i,
    output logic [CNT_W-1:0] per_o,
    output logic             bad_o
);
    logic [CNT_W-1:0] stage_d, stage_q;
    logic [CNT_W-1:0] act_d, act_q;

    always_comb begin
        stage_d = wr_i ? wdata_i : stage_q;
        act_d   = (load_i || idle_i) ? stage_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            act_q   <= '0;
        end else begin
            stage_q <= stage_d;
            act_q   <= act_d;
        end
    end

    assign per_o = act_q;
    assign bad_o = (act_q == {{(CNT_W-1){1'b0}}, 1'b1});

    // R9
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || idle_i) |=> $stable(per_o));

    // R10
    per_idle_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (per_o == $past(stage_q)));

endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W        = 15,
    parameter int POST_W       = 4,
    parameter int PSEL_W       = 2,
    parameter int PRE_STEP_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_en_i,
    input  logic [1:0]        ctl_mode_i,
    input  logic [PSEL_W-1:0] ctl_pre_i,
    input  logic [POST_W-1:0] ctl_post_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic              per_wr_i,
    input  logic [CNT_W-1:0]  per_wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              dir_down_o,
    output logic              event_o,
    output logic              run_o,
    output logic              per_bad_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              en;
        tb_mode_e          mode;
        logic [PSEL_W-1:0] pre;
        logic [POST_W-1:0] post;
        logic [CNT_W-1:0]  cnt;
        logic              down;
        logic              ev;
    } core_t;

    core_t core_d, core_q;

    logic             pre_stroke;
    logic             post_fire;
    logic             step;
    logic             any_wr;
    logic             period_end;
    logic             per_load;
    logic             top_hit;
    logic             bot_hit;
    logic [CNT_W-1:0] per_act;

    assign any_wr = ctl_wr_i || cnt_wr_i;

    pwm_tbase_presc #(
        .SEL_W    (PSEL_W),
        .STEP_LOG (PRE_STEP_LOG)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (any_wr),
        .adv_i    (core_q.en && tick_i),
        .sel_i    (core_q.pre),
        .stroke_o (pre_stroke)
    );

    pwm_tbase_post #(
        .POST_W (POST_W)
    ) post_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (any_wr),
        .hit_i   (period_end),
        .ratio_i (core_q.post),
        .fire_o  (post_fire)
    );

    pwm_tbase_period #(
        .CNT_W (CNT_W)
    ) period_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (per_wr_i),
        .wdata_i (per_wdata_i),
        .load_i  (per_load),
        .idle_i  (!core_q.en),
        .per_o   (per_act),
        .bad_o   (per_bad_o)
    );

    // Step decode: direction, reversal points and period ends.
    always_comb begin
        step    = core_q.en && tick_i && pre_stroke && !any_wr;
        top_hit = 1'b0;
        bot_hit = 1'b0;
        per_load = 1'b0;
        if (step) begin
            if (!mode_is_updn(core_q.mode)) begin
                per_load = (core_q.cnt >= per_act);
            end else if (!core_q.down) begin
                top_hit = (core_q.cnt >= per_act);
            end else begin
                bot_hit  = (core_q.cnt == '0);
                per_load = bot_hit;
            end
        end
        period_end = 1'b0;
        if (core_q.mode == MODE_FREE) period_end = per_load;
        if (core_q.mode == MODE_UPDN) period_end = bot_hit;
    end

    // Next-state computation.
    always_comb begin
        core_d    = core_q;
        core_d.ev = 1'b0;
        if (step) begin
            if (!mode_is_updn(core_q.mode)) begin
                if (per_load) begin
                    core_d.cnt = '0;
                    if (core_q.mode == MODE_ONCE) begin
                        core_d.en = 1'b0;
                        core_d.ev = 1'b1;
                    end
                end else begin
                    core_d.cnt = core_q.cnt + CNT_ONE;
                end
            end else if (!core_q.down) begin
                if (top_hit) begin
                    if (core_q.cnt != '0) begin
                        core_d.down = 1'b1;
                        core_d.cnt  = core_q.cnt - CNT_ONE;
                    end
                end else begin
                    core_d.cnt = core_q.cnt + CNT_ONE;
                end
            end else begin
                if (bot_hit) begin
                    core_d.down = 1'b0;
                    core_d.cnt  = CNT_ONE;
                end else begin
                    core_d.cnt = core_q.cnt - CNT_ONE;
                end
            end
        end
        if (core_q.mode == MODE_UPDN2) begin
            if (top_hit || bot_hit) core_d.ev = 1'b1;
        end
        if (post_fire) core_d.ev = 1'b1;

        if (cnt_wr_i) core_d.cnt = cnt_wdata_i;
        if (ctl_wr_i) begin
            core_d.en   = ctl_en_i;
            core_d.mode = tb_mode_e'(ctl_mode_i);
            core_d.pre  = ctl_pre_i;
            core_d.post = ctl_post_i;
            if (!ctl_mode_i[1]) core_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{en: 1'b0, mode: MODE_FREE, pre: '0, post: '0,
                        cnt: '0, down: 1'b0, ev: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign count_o    = core_q.cnt;
    assign dir_down_o = core_q.down;
    assign event_o    = core_q.ev;
    assign run_o      = core_q.en;

    // R5
    once_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && core_q.mode == MODE_ONCE) |-> !run_o);

    // R6
    dir_only_updn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_down_o |-> mode_is_updn(core_q.mode));

    // R12
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(count_o));

    // R3
    ctl_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !cnt_wr_i) |=> (count_o == $past(count_o)));

endmodule

// File: tb/pwm_tbase_tb_top.sv
`timescale 1ns/1ps
module pwm_tbase_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        ctl_wr_i = 1'b0;
    logic        ctl_en_i = 1'b0;
    logic [1:0]  ctl_mode_i = 2'b00;
    logic [1:0]  ctl_pre_i = 2'b00;
    logic [3:0]  ctl_post_i = 4'd0;
    logic        cnt_wr_i = 1'b0;
    logic [14:0] cnt_wdata_i = '0;
    logic        per_wr_i = 1'b0;
    logic [14:0] per_wdata_i = '0;
    logic [14:0] count_o;
    logic        dir_down_o, event_o, run_o, per_bad_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_tbase dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .ctl_wr_i(ctl_wr_i), .ctl_en_i(ctl_en_i), .ctl_mode_i(ctl_mode_i),
        .ctl_pre_i(ctl_pre_i), .ctl_post_i(ctl_post_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .per_wr_i(per_wr_i), .per_wdata_i(per_wdata_i),
        .count_o(count_o), .dir_down_o(dir_down_o), .event_o(event_o),
        .run_o(run_o), .per_bad_o(per_bad_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int m_en, m_mode, m_pre, m_post, m_pc, m_qc, m_cnt, m_down, m_buf, m_act, m_ev;

    always @(posedge clk) begin
        int lim, n_pc, n_qc, n_cnt, n_down, n_en, n_act;
        bit wr, stp, pend, load, ev;
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_pre = 0; m_post = 0; m_pc = 0; m_qc = 0;
            m_cnt = 0; m_down = 0; m_buf = 0; m_act = 0; m_ev = 0;
        end else begin
            lim = (1 << (2 * m_pre)) - 1;
            wr = ctl_wr_i || cnt_wr_i;
            stp = (m_en != 0) && tick_i && (m_pc == lim) && !wr;
            if (wr) n_pc = 0;
            else if (m_en != 0 && tick_i) n_pc = (m_pc == lim) ? 0 : m_pc + 1;
            else n_pc = m_pc;
            ev = 0; pend = 0; load = 0;
            n_cnt = m_cnt; n_down = m_down; n_en = m_en; n_qc = m_qc;
            if (stp) begin
                if (m_mode < 2) begin
                    if (m_cnt >= m_act) begin
                        n_cnt = 0; load = 1;
                        if (m_mode == 1) begin n_en = 0; ev = 1; end
                        else pend = 1;
                    end else n_cnt = m_cnt + 1;
                end else if (m_down == 0) begin
                    if (m_cnt >= m_act) begin
                        if (m_mode == 3) ev = 1;
                        if (m_cnt != 0) begin n_down = 1; n_cnt = m_cnt - 1; end
                    end else n_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        if (m_mode == 3) ev = 1; else pend = 1;
                        load = 1; n_down = 0; n_cnt = 1;
                    end else n_cnt = m_cnt - 1;
                end
            end
            if (wr) n_qc = 0;
            else if (pend) begin
                if (m_qc == m_post) begin ev = 1; n_qc = 0; end
                else n_qc = m_qc + 1;
            end
            n_act = (load || m_en == 0) ? m_buf : m_act;
            if (per_wr_i) m_buf = int'(per_wdata_i);
            if (cnt_wr_i) n_cnt = int'(cnt_wdata_i);
            if (ctl_wr_i) begin
                n_en = int'(ctl_en_i); m_mode = int'(ctl_mode_i);
                m_pre = int'(ctl_pre_i); m_post = int'(ctl_post_i);
                if (ctl_mode_i[1] == 1'b0) n_down = 0;
            end
            m_pc = n_pc; m_qc = n_qc; m_cnt = n_cnt; m_down = n_down;
            m_en = n_en; m_act = n_act; m_ev = int'(ev);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 count vs model", int'(count_o), m_cnt);
            check("R7 event vs model", int'(event_o), m_ev);
            check("R5 run vs model", int'(run_o), m_en);
            check("R6 dir vs model", int'(dir_down_o), m_down);
            check("R11 per_bad vs model", int'(per_bad_o), int'(m_act == 1));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(bit en, int mode, int pre, int post);
        ctl_wr_i = 1'b1; ctl_en_i = en; ctl_mode_i = 2'(mode);
        ctl_pre_i = 2'(pre); ctl_post_i = 4'(post);
        @(negedge clk);
        ctl_wr_i = 1'b0;
    endtask

    task automatic wr_per(int v);
        per_wr_i = 1'b1; per_wdata_i = 15'(v);
        @(negedge clk);
        per_wr_i = 1'b0;
    endtask

    task automatic wr_cnt(int v);
        cnt_wr_i = 1'b1; cnt_wdata_i = 15'(v);
        @(negedge clk);
        cnt_wr_i = 1'b0;
    endtask

    task automatic wait_ev(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!event_o && n < 1000);
    endtask

    initial begin
        int n;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 count", int'(count_o), 0);
        check("R1 run", int'(run_o), 0);
        check("R1 dir", int'(dir_down_o), 0);
        check("R1 event", int'(event_o), 0);
        check("R1 per_bad", int'(per_bad_o), 0);

        tick_i = 1'b1;
        wr_per(1000);
        idle(2);
        ctl(1, 0, 1, 0);
        idle(40);
        check("R2 divide by 4", int'(count_o), 10);

        tick_i = 1'b0;
        idle(20);
        check("R12 no tick hold", int'(count_o), 10);
        tick_i = 1'b1;

        idle(2);
        ctl(1, 0, 1, 0);
        check("R3 ctl write keeps count", int'(count_o), 10);
        idle(3);
        check("R3 divider restarted", int'(count_o), 10);
        idle(1);
        check("R3 step after full divide", int'(count_o), 11);
        wr_cnt(500);
        check("R3 count write", int'(count_o), 500);

        ctl(0, 0, 0, 0);
        wr_per(3);
        idle(2);
        ctl(1, 0, 0, 2);
        wait_ev(n);
        wait_ev(n);
        check("R7 event every 3 periods", n, 12);
        ctl(1, 0, 0, 0);
        wait_ev(n);
        check("R4 count zero at wrap", int'(count_o), 0);
        wait_ev(n);
        check("R4 free period", n, 4);

        wr_per(8);
        wait_ev(n);
        wait_ev(n);
        wait_ev(n);
        check("R9 new period after wrap", n, 9);

        ctl(0, 0, 0, 0);
        wr_per(1);
        idle(1);
        check("R10 idle copy", int'(per_bad_o), 1);
        check("R11 period one flagged", int'(per_bad_o), 1);
        wr_per(6);
        idle(1);
        check("R10 idle copy again", int'(per_bad_o), 0);

        wr_cnt(0);
        ctl(1, 1, 0, 5);
        wait_ev(n);
        check("R5 single period length", n, 7);
        check("R5 run cleared", int'(run_o), 0);
        idle(10);
        check("R5 stays at zero", int'(count_o), 0);

        wr_per(4);
        idle(1);
        ctl(1, 2, 0, 0);
        wait_ev(n);
        wait_ev(n);
        check("R6 up/down length", n, 8);
        check("R6 count after bottom", int'(count_o), 1);
        idle(4);
        check("R6 falling count", int'(count_o), 3);
        check("R6 dir down", int'(dir_down_o), 1);

        ctl(1, 3, 0, 7);
        wait_ev(n);
        wait_ev(n);
        check("R8 half period event", n, 4);
        wait_ev(n);
        check("R8 other half event", n, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule